// File: doc/BRIEF.md
# Per-Line MOESI Coherence Controller

This block keeps the coherence state of a single cache line for a snooping, broadcast-based MOESI-style protocol. Every cycle it may receive one event, which is a processor access, a request forwarded from another agent, a response, or a completion notice. From the current state and that event it works out the outgoing action, the next state and whether the event has to be retried later. Dirty data has two owner states. In the dirty-exclusive state a store is still needed before the line counts as locally modified. In the locally modified state a plain read from another agent moves the whole line to that agent (migratory sharing), unless the line was touched by an atomic and migration is disabled. Several wait states hold exclusive data until every ack has come back, and a writeback race state can retire on either an ack or a nack.

The event interface is valid-only. The controller takes an event in any cycle where `ev_valid` is high and does not stall the sender. Back-pressure is given per event through `recycle_o`: when it is high in the same cycle as the event, the event has been declined without effect and the sender must present it again later. The action vector, the recycle strobe, the error flag and the pending-count increment are combinational outputs of the presented event. The state and the permission change at the next clock edge. Data storage, the network and the ack counter live outside this block.

Top module: `line_coh_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the state is I (code 0), the permission is none and no strobe is active. A cycle with `ev_valid` low produces no strobe and leaves the state unchanged, whatever the other inputs are.
- R2: The permission output is read-write (3) only in MM (4) and MM_W (10). It is read-only (1) in S (1), M_W (9) and ISM (8). It is none (0) in every other state. State codes: I 0, S 1, O 2, M 3, MM 4, IM 5, SM 6, OM 7, ISM 8, M_W 9, MM_W 10, IS 11, SS 12, OI 13, MI 14, II 15.
- R3: Processor events use codes load 0, ifetch 1, store 2 and replacement 3. A load or ifetch in I issues GETS (action bit 5) and moves to IS. A store in I issues GETX (bit 6) and moves to IM. A store in S issues GETX and moves to SM. A store in O issues GETX and moves to OM. A store in M moves to MM with no action. Loads in S, O, M and MM, and stores in MM, are hits with no action. A replacement in S drops the line to I silently, and a replacement in I does nothing.
- R4: A replacement in O moves to OI. A replacement in M or MM moves to MI. Both issue PUT (bit 7).
- R5: Forwarded requests use codes GETS 4 and GETX 7. In MM, a GETS sends exclusive data (bit 2) and moves to I. If `line_atomic` and `no_mig_en` are both high, the GETS instead sends shared data (bit 1) and moves to O. In M, a GETS sends shared data and moves to O. In M or MM, a GETX or invalidate (code 8) sends exclusive data and moves to I. In O, a GETS sends shared data and stays in O, while a GETX or invalidate sends data (bit 0) and moves to I. In S, a GETS sends a shared ack (bit 4), and a GETX or invalidate sends an ack (bit 3) and moves to I. In I, every forwarded request is answered with an ack.
- R6: A merged GETS (code 5) in MM or M sends shared data and moves to O. A DMA-only GETS (code 6) leaves S, O, M and MM unchanged and sends a shared ack in S or shared data in the others.
- R7: Responses use codes ack 11, shared ack 12, data 13, shared data 14 and exclusive data 15. In IS, data or shared data moves to SS and exclusive data moves to M_W. In IM or SM, data or shared data moves to ISM and exclusive data moves to MM_W. Acks cause no state change in the waiting states.
- R8: Completion events are all-acks (16) and all-acks-no-sharers (17). SS goes to S and sends an S-unblock (bit 12) on either completion. ISM, OM and MM_W go to MM on either completion, and M_W goes to M on all-acks-no-sharers only. Each of these last four sends an M-unblock (bit 13). A store in M_W moves to MM_W with no action.
- R9: In OI or MI, a GETX or invalidate sends data from the writeback buffer and moves to II, and a GETS sends shared data with no change of state. A writeback ack (code 9) in OI sends a writeback (bit 8 when `line_dirty` is low, bit 9 when high) and moves to I. In MI it sends an exclusive writeback (bit 10 clean, bit 11 dirty) and moves to I. In II, a writeback ack or a writeback nack (code 10) moves to I with no action.
- R10: Stores and replacements in transient states raise `recycle_o` and change nothing. The exceptions are a store in M_W (R8) and a store in MM_W, which is a hit. Loads are recycled in IM, IS, OI, MI and II and are hits in the other transient states. Forwarded requests are recycled in M_W and MM_W.
- R11: In OM, a GETX or invalidate sends data, raises `pend_inc_o` and moves to IM. In SM, a GETX or invalidate sends an ack and moves to IM, and a GETS sends a shared ack. In IM, ISM, IS, SS and II, forwarded requests are answered with an ack and the state is unchanged.
- R12: An event that is not legal in the current state raises `err_o` with no action and no state change. This covers any code above 17, any response in a stable state, and a writeback ack or nack outside OI, MI and II (a nack is also illegal in OI and MI).
- R13: The action vector has at most one bit set per event. `recycle_o`, `err_o` and the action vector never carry an effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_code | input | 5 | Event code (see R3 to R12) |
| line_atomic | input | 1 | The line was touched by an atomic access |
| no_mig_en | input | 1 | Disable migration of atomic-touched lines |
| line_dirty | input | 1 | The buffered line is dirty (selects writeback flavour) |
| state_o | output | 4 | Current state code |
| perm_o | output | 2 | Access permission: 0 none, 1 read-only, 3 read-write |
| act_o | output | 14 | Action strobes, at most one bit set |
| pend_inc_o | output | 1 | Add one to the external pending-message count |
| recycle_o | output | 1 | Event declined, present again later |
| err_o | output | 1 | Event illegal in the current state |

## Verification
The assertions assume that `ev_code` and the three line qualifiers are stable for the whole cycle in which `ev_valid` is high. They also assume that no more than one event arrives per cycle, and that `line_dirty` reflects the buffered copy when a writeback ack arrives. The stimulus keeps to this by changing every input only on the falling clock edge, presenting one event at a time, and dropping `ev_valid` after each rising edge. Illegal events are sent on purpose in a few steps, so that the hold-on-error behaviour is exercised and not assumed.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  localparam int ST_W   = 4;
  localparam int EV_W   = 5;
  localparam int PERM_W = 2;
  localparam int ACT_W  = 14;
  localparam int EV_IN_MAX = 17;

  typedef enum logic [ST_W-1:0] {
    ST_I = 4'd0, ST_S = 4'd1, ST_O = 4'd2, ST_M = 4'd3, ST_MM = 4'd4,
    ST_IM = 4'd5, ST_SM = 4'd6, ST_OM = 4'd7, ST_ISM = 4'd8,
    ST_MW = 4'd9, ST_MMW = 4'd10, ST_IS = 4'd11, ST_SS = 4'd12,
    ST_OI = 4'd13, ST_MI = 4'd14, ST_II = 4'd15
  } coh_state_e;

  typedef enum logic [EV_W-1:0] {
    EV_LOAD = 5'd0, EV_IFETCH = 5'd1, EV_STORE = 5'd2, EV_REPL = 5'd3,
    EV_FGETS = 5'd4, EV_FMGETS = 5'd5, EV_FDMA = 5'd6, EV_FGETX = 5'd7,
    EV_FINV = 5'd8, EV_WBACK = 5'd9, EV_WBNACK = 5'd10,
    EV_ACK = 5'd11, EV_SACK = 5'd12, EV_DATA = 5'd13, EV_SDATA = 5'd14,
    EV_XDATA = 5'd15, EV_DONE = 5'd16, EV_DONE_NOSH = 5'd17,
    EV_FGETS_NM = 5'd18, EV_BAD = 5'd19
  } coh_ev_e;

  typedef enum logic [PERM_W-1:0] {
    PERM_NONE = 2'd0, PERM_RO = 2'd1, PERM_RW = 2'd3
  } coh_perm_e;

  localparam int A_DATA   = 0;
  localparam int A_DSH    = 1;
  localparam int A_DEX    = 2;
  localparam int A_ACK    = 3;
  localparam int A_ASH    = 4;
  localparam int A_GETS   = 5;
  localparam int A_GETX   = 6;
  localparam int A_PUT    = 7;
  localparam int A_WBC    = 8;
  localparam int A_WBD    = 9;
  localparam int A_WXC    = 10;
  localparam int A_WXD    = 11;
  localparam int A_UBS    = 12;
  localparam int A_UBM    = 13;
endpackage

// File: rtl/coh_ev_classify.sv
`timescale 1ns/1ps
module coh_ev_classify
  import coh_pkg::*;
(
  input  logic [EV_W-1:0] ev_code,
  input  logic            line_atomic,
  input  logic            no_mig_en,
  output coh_ev_e         ev
);
  always_comb begin
    if (ev_code > EV_W'(EV_IN_MAX)) begin
      ev = EV_BAD;
    end else if (ev_code == EV_FGETS && line_atomic && no_mig_en) begin
      ev = EV_FGETS_NM;  // R5: migration suppressed
    end else begin
      ev = coh_ev_e'(ev_code);
    end
  end
endmodule

// File: rtl/coh_perm_map.sv
`timescale 1ns/1ps
module coh_perm_map
  import coh_pkg::*;
(
  input  coh_state_e st,
  output coh_perm_e  perm
);
  always_comb begin
    unique case (st)
      ST_MM, ST_MMW:       perm = PERM_RW;
      ST_S, ST_MW, ST_ISM: perm = PERM_RO;
      default:             perm = PERM_NONE;
    endcase
  end
endmodule

// File: rtl/coh_xition.sv
`timescale 1ns/1ps
module coh_xition
  import coh_pkg::*;
(
  input  coh_state_e       cur,
  input  coh_ev_e          ev,
  input  logic             live,
  input  logic             line_dirty,
  output coh_state_e       nxt,
  output logic [ACT_W-1:0] act,
  output logic             rec,
  output logic             bad,
  output logic             pinc
);
  logic rd, st, rp, fr, fx, rsp_ack, dat, done;

  always_comb begin
    rd      = (ev == EV_LOAD) || (ev == EV_IFETCH);
    st      = (ev == EV_STORE);
    rp      = (ev == EV_REPL);
    fr      = (ev == EV_FGETS) || (ev == EV_FGETS_NM) || (ev == EV_FMGETS) || (ev == EV_FDMA);
    fx      = (ev == EV_FGETX) || (ev == EV_FINV);
    rsp_ack = (ev == EV_ACK) || (ev == EV_SACK);
    dat     = (ev == EV_DATA) || (ev == EV_SDATA);
    done    = (ev == EV_DONE) || (ev == EV_DONE_NOSH);
  end

  always_comb begin
    nxt  = cur;
    act  = '0;
    rec  = 1'b0;
    bad  = 1'b0;
    pinc = 1'b0;
    if (live) begin
      unique case (cur)
        // R3 / R5: invalid line
        ST_I: begin
          if (rd)            begin nxt = ST_IS; act[A_GETS] = 1'b1; end
          else if (st)       begin nxt = ST_IM; act[A_GETX] = 1'b1; end
          else if (rp)       begin end
          else if (fr || fx) act[A_ACK] = 1'b1;
          else               bad = 1'b1;
        end
        ST_S: begin
          if (rd)            begin end
          else if (st)       begin nxt = ST_SM; act[A_GETX] = 1'b1; end
          else if (rp)       nxt = ST_I;
          else if (fr)       act[A_ASH] = 1'b1;  // R6 DMA and merged too
          else if (fx)       begin nxt = ST_I; act[A_ACK] = 1'b1; end
          else               bad = 1'b1;
        end
        ST_O: begin
          if (rd)            begin end
          else if (st)       begin nxt = ST_OM; act[A_GETX] = 1'b1; end
          else if (rp)       begin nxt = ST_OI; act[A_PUT] = 1'b1; end
          else if (fr)       act[A_DSH] = 1'b1;
          else if (fx)       begin nxt = ST_I; act[A_DATA] = 1'b1; end
          else               bad = 1'b1;
        end
        ST_M: begin
          if (rd)            begin end
          else if (st)       nxt = ST_MM;
          else if (rp)       begin nxt = ST_MI; act[A_PUT] = 1'b1; end
          else if (ev == EV_FDMA) act[A_DSH] = 1'b1;
          else if (fr)       begin nxt = ST_O; act[A_DSH] = 1'b1; end
          else if (fx)       begin nxt = ST_I; act[A_DEX] = 1'b1; end
          else               bad = 1'b1;
        end
        ST_MM: begin
          if (rd || st)      begin end
          else if (rp)       begin nxt = ST_MI; act[A_PUT] = 1'b1; end
          else if (ev == EV_FGETS) begin nxt = ST_I; act[A_DEX] = 1'b1; end
          else if (ev == EV_FDMA)  act[A_DSH] = 1'b1;
          else if (fr)       begin nxt = ST_O; act[A_DSH] = 1'b1; end
          else if (fx)       begin nxt = ST_I; act[A_DEX] = 1'b1; end
          else               bad = 1'b1;
        end
        // R7: waiting for data after a GETX
        ST_IM: begin
          if (rd || st || rp) rec = 1'b1;
          else if (fr || fx)  act[A_ACK] = 1'b1;
          else if (rsp_ack)   begin end
          else if (dat)       nxt = ST_ISM;
          else if (ev == EV_XDATA) nxt = ST_MMW;
          else                bad = 1'b1;
        end
        ST_SM: begin
          if (rd)             begin end
          else if (st || rp)  rec = 1'b1;
          else if (fr)        act[A_ASH] = 1'b1;
          else if (fx)        begin nxt = ST_IM; act[A_ACK] = 1'b1; end
          else if (rsp_ack)   begin end
          else if (dat)       nxt = ST_ISM;
          else if (ev == EV_XDATA) nxt = ST_MMW;
          else                bad = 1'b1;
        end
        ST_OM: begin
          if (rd)             begin end
          else if (st || rp)  rec = 1'b1;
          else if (fr)        act[A_DSH] = 1'b1;
          else if (fx)        begin nxt = ST_IM; act[A_DATA] = 1'b1; pinc = 1'b1; end
          else if (rsp_ack)   begin end
          else if (done)      begin nxt = ST_MM; act[A_UBM] = 1'b1; end
          else                bad = 1'b1;
        end
        ST_ISM: begin
          if (rd)             begin end
          else if (st || rp)  rec = 1'b1;
          else if (fr || fx)  act[A_ACK] = 1'b1;
          else if (rsp_ack)   begin end
          else if (done)      begin nxt = ST_MM; act[A_UBM] = 1'b1; end
          else                bad = 1'b1;
        end
        ST_MW: begin
          if (rd)             begin end
          else if (st)        nxt = ST_MMW;
          else if (rp || fr || fx) rec = 1'b1;
          else if (rsp_ack)   begin end
          else if (ev == EV_DONE_NOSH) begin nxt = ST_M; act[A_UBM] = 1'b1; end
          else                bad = 1'b1;
        end
        ST_MMW: begin
          if (rd || st)       begin end
          else if (rp || fr || fx) rec = 1'b1;
          else if (rsp_ack)   begin end
          else if (done)      begin nxt = ST_MM; act[A_UBM] = 1'b1; end
          else                bad = 1'b1;
        end
        ST_IS: begin
          if (rd || st || rp) rec = 1'b1;
          else if (fr || fx)  act[A_ACK] = 1'b1;
          else if (rsp_ack)   begin end
          else if (dat)       nxt = ST_SS;
          else if (ev == EV_XDATA) nxt = ST_MW;
          else                bad = 1'b1;
        end
        ST_SS: begin
          if (rd)             begin end
          else if (st || rp)  rec = 1'b1;
          else if (fr || fx)  act[A_ACK] = 1'b1;
          else if (rsp_ack)   begin end
          else if (done)      begin nxt = ST_S; act[A_UBS] = 1'b1; end
          else                bad = 1'b1;
        end
        ST_OI, ST_MI: begin
          if (rd || st || rp) rec = 1'b1;
          else if (fr)        act[A_DSH] = 1'b1;
          else if (fx)        begin nxt = ST_II; act[A_DATA] = 1'b1; end
          else if (ev == EV_WBACK) begin
            nxt = ST_I;
            if (cur == ST_MI) begin
              if (line_dirty) act[A_WXD] = 1'b1;
              else            act[A_WXC] = 1'b1;
            end else begin
              if (line_dirty) act[A_WBD] = 1'b1;
              else            act[A_WBC] = 1'b1;
            end
          end
          else                bad = 1'b1;
        end
        ST_II: begin
          if (rd || st || rp) rec = 1'b1;
          else if (fr || fx)  act[A_ACK] = 1'b1;
          else if (ev == EV_WBACK || ev == EV_WBNACK) nxt = ST_I;
          else                bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/line_coh_ctrl.sv
`timescale 1ns/1ps
module line_coh_ctrl
  import coh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [EV_W-1:0]   ev_code,
  input  logic              line_atomic,
  input  logic              no_mig_en,
  input  logic              line_dirty,
  output logic [ST_W-1:0]   state_o,
  output logic [PERM_W-1:0] perm_o,
  output logic [ACT_W-1:0]  act_o,
  output logic              pend_inc_o,
  output logic              recycle_o,
  output logic              err_o
);
  coh_state_e st_q, st_d;
  coh_ev_e    ev;
  coh_perm_e  perm;

  coh_ev_classify u_cls (
    .ev_code(ev_code), .line_atomic(line_atomic), .no_mig_en(no_mig_en), .ev(ev)
  );

  coh_xition u_xit (
    .cur(st_q), .ev(ev), .live(ev_valid), .line_dirty(line_dirty),
    .nxt(st_d), .act(act_o), .rec(recycle_o), .bad(err_o), .pinc(pend_inc_o)
  );

  coh_perm_map u_perm (.st(st_q), .perm(perm));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_I;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
  assign perm_o  = perm;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (act_o == '0 && !recycle_o && !err_o && !pend_inc_o));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(state_o));
  p_rw_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_o == PERM_RW) |-> (st_q == ST_MM || st_q == ST_MMW));
  p_put_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[A_PUT] |=> (st_q == ST_OI || st_q == ST_MI));
  p_unblock_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[A_UBM] |=> (st_q == ST_M || st_q == ST_MM));
  p_wb_to_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o[A_WBC] || act_o[A_WBD] || act_o[A_WXC] || act_o[A_WXD]) |=> (st_q == ST_I));
  p_recycle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recycle_o |=> $stable(state_o));
  p_pend_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_inc_o |=> (st_q == ST_IM));
  p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> $stable(state_o));
  p_act_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_o));
  p_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (recycle_o || err_o) |-> (act_o == '0 && !(recycle_o && err_o)));
endmodule

// File: tb/test_line_coh_ctrl.sv
`timescale 1ns/1ps
module test_line_coh_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [4:0]  ev_code = 5'd0;
  logic        line_atomic = 1'b0;
  logic        no_mig_en = 1'b0;
  logic        line_dirty = 1'b0;
  logic [3:0]  state_o;
  logic [1:0]  perm_o;
  logic [13:0] act_o;
  logic        pend_inc_o, recycle_o, err_o;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_coh_ctrl i_line_coh_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .line_atomic(line_atomic), .no_mig_en(no_mig_en), .line_dirty(line_dirty),
    .state_o(state_o), .perm_o(perm_o), .act_o(act_o), .pend_inc_o(pend_inc_o),
    .recycle_o(recycle_o), .err_o(err_o)
  );

  localparam logic N = 1'b0, Y = 1'b1;
  localparam logic [4:0] ELD = 5'd0, EIF = 5'd1, EST = 5'd2, ERP = 5'd3, EGS = 5'd4,
    EMG = 5'd5, EDM = 5'd6, EGX = 5'd7, EIV = 5'd8, EWA = 5'd9, EWN = 5'd10,
    ESA = 5'd12, EAK = 5'd11, EDT = 5'd13, ESD = 5'd14, EXD = 5'd15, ECA = 5'd16,
    ECN = 5'd17, EBAD = 5'd20;
  localparam logic [3:0] QI = 4'd0, QS = 4'd1, QO = 4'd2, QM = 4'd3, QMM = 4'd4,
    QIM = 4'd5, QSM = 4'd6, QOM = 4'd7, QISM = 4'd8, QMW = 4'd9, QMMW = 4'd10,
    QIS = 4'd11, QSS = 4'd12, QOI = 4'd13, QMI = 4'd14, QII = 4'd15;
  localparam logic [13:0] XN = 14'h0, XDATA = 14'h0001, XDSH = 14'h0002, XDEX = 14'h0004,
    XACK = 14'h0008, XASH = 14'h0010, XGETS = 14'h0020, XGETX = 14'h0040, XPUT = 14'h0080,
    XWBD = 14'h0200, XWXC = 14'h0400, XWXD = 14'h0800, XUBS = 14'h1000, XUBM = 14'h2000;

  typedef struct packed {
    logic [3:0]  rq;
    logic [4:0]  code;
    logic        atom;
    logic        nomig;
    logic        dirty;
    logic [3:0]  nxt;
    logic [13:0] act;
    logic        rec;
    logic        err;
    logic        pinc;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  ELD, N,N,N, QIS,  XGETS, N,N,N},
    '{4'd10, EST, N,N,N, QIS,  XN,    Y,N,N},
    '{4'd10, ELD, N,N,N, QIS,  XN,    Y,N,N},
    '{4'd11, EGS, N,N,N, QIS,  XACK,  N,N,N},
    '{4'd7,  EAK, N,N,N, QIS,  XN,    N,N,N},
    '{4'd7,  ESD, N,N,N, QSS,  XN,    N,N,N},
    '{4'd10, ELD, N,N,N, QSS,  XN,    N,N,N},
    '{4'd8,  ECA, N,N,N, QS,   XUBS,  N,N,N},
    '{4'd5,  EGS, N,N,N, QS,   XASH,  N,N,N},
    '{4'd6,  EDM, N,N,N, QS,   XASH,  N,N,N},
    '{4'd3,  EST, N,N,N, QSM,  XGETX, N,N,N},
    '{4'd11, EGS, N,N,N, QSM,  XASH,  N,N,N},
    '{4'd7,  EDT, N,N,N, QISM, XN,    N,N,N},
    '{4'd10, ERP, N,N,N, QISM, XN,    Y,N,N},
    '{4'd8,  ECN, N,N,N, QMM,  XUBM,  N,N,N},
    '{4'd3,  EST, N,N,N, QMM,  XN,    N,N,N},
    '{4'd5,  EGS, Y,Y,N, QO,   XDSH,  N,N,N},
    '{4'd3,  EST, N,N,N, QOM,  XGETX, N,N,N},
    '{4'd11, EGX, N,N,N, QIM,  XDATA, N,N,Y},
    '{4'd10, ELD, N,N,N, QIM,  XN,    Y,N,N},
    '{4'd7,  EXD, N,N,N, QMMW, XN,    N,N,N},
    '{4'd10, EST, N,N,N, QMMW, XN,    N,N,N},
    '{4'd10, EGS, N,N,N, QMMW, XN,    Y,N,N},
    '{4'd8,  ECA, N,N,N, QMM,  XUBM,  N,N,N},
    '{4'd5,  EGS, Y,N,N, QI,   XDEX,  N,N,N},
    '{4'd3,  EIF, N,N,N, QIS,  XGETS, N,N,N},
    '{4'd7,  EXD, N,N,N, QMW,  XN,    N,N,N},
    '{4'd12, ECA, N,N,N, QMW,  XN,    N,Y,N},
    '{4'd8,  ECN, N,N,N, QM,   XUBM,  N,N,N},
    '{4'd5,  EGS, N,N,N, QO,   XDSH,  N,N,N},
    '{4'd4,  ERP, N,N,N, QOI,  XPUT,  N,N,N},
    '{4'd10, ELD, N,N,N, QOI,  XN,    Y,N,N},
    '{4'd9,  EGS, N,N,N, QOI,  XDSH,  N,N,N},
    '{4'd9,  EWA, N,N,Y, QI,   XWBD,  N,N,N},
    '{4'd3,  EST, N,N,N, QIM,  XGETX, N,N,N},
    '{4'd7,  EDT, N,N,N, QISM, XN,    N,N,N},
    '{4'd8,  ECA, N,N,N, QMM,  XUBM,  N,N,N},
    '{4'd4,  ERP, N,N,N, QMI,  XPUT,  N,N,N},
    '{4'd9,  EWA, N,N,N, QI,   XWXC,  N,N,N},
    '{4'd12, EWA, N,N,N, QI,   XN,    N,Y,N},
    '{4'd12, EBAD,N,N,N, QI,   XN,    N,Y,N},
    '{4'd5,  EGX, N,N,N, QI,   XACK,  N,N,N},
    '{4'd3,  EST, N,N,N, QIM,  XGETX, N,N,N},
    '{4'd7,  EDT, N,N,N, QISM, XN,    N,N,N},
    '{4'd8,  ECN, N,N,N, QMM,  XUBM,  N,N,N},
    '{4'd6,  EMG, N,N,N, QO,   XDSH,  N,N,N},
    '{4'd5,  EGX, N,N,N, QI,   XDATA, N,N,N},
    '{4'd3,  ELD, N,N,N, QIS,  XGETS, N,N,N},
    '{4'd7,  EXD, N,N,N, QMW,  XN,    N,N,N},
    '{4'd8,  EST, N,N,N, QMMW, XN,    N,N,N},
    '{4'd8,  ECN, N,N,N, QMM,  XUBM,  N,N,N},
    '{4'd5,  EGX, N,N,N, QI,   XDEX,  N,N,N},
    '{4'd3,  ELD, N,N,N, QIS,  XGETS, N,N,N},
    '{4'd7,  EXD, N,N,N, QMW,  XN,    N,N,N},
    '{4'd8,  ECN, N,N,N, QM,   XUBM,  N,N,N},
    '{4'd4,  ERP, N,N,N, QMI,  XPUT,  N,N,N},
    '{4'd9,  EIV, N,N,N, QII,  XDATA, N,N,N},
    '{4'd10, ELD, N,N,N, QII,  XN,    Y,N,N},
    '{4'd9,  EWN, N,N,N, QI,   XN,    N,N,N},
    '{4'd3,  ELD, N,N,N, QIS,  XGETS, N,N,N},
    '{4'd7,  EDT, N,N,N, QSS,  XN,    N,N,N},
    '{4'd8,  ECN, N,N,N, QS,   XUBS,  N,N,N},
    '{4'd3,  ERP, N,N,N, QI,   XN,    N,N,N}
  };

  // R2: permission expected from the state code
  function automatic logic [1:0] perm_of(input logic [3:0] s);
    if (s == QMM || s == QMMW) return 2'd3;
    if (s == QS || s == QMW || s == QISM) return 2'd1;
    return 2'd0;
  endfunction

  task automatic apply(input vec_t v, input int idx);
    bit bad = 1'b0;
    @(negedge clk);
    ev_valid = 1'b1; ev_code = v.code; line_atomic = v.atom;
    no_mig_en = v.nomig; line_dirty = v.dirty;
    #1;
    nchk++;
    if ($countones(act_o) > 1) begin
      bad = 1'b1;
      $display("FAIL R13 step %0d: act=%h expected at most one bit", idx, act_o);
    end
    if (act_o !== v.act || recycle_o !== v.rec || err_o !== v.err || pend_inc_o !== v.pinc) begin
      bad = 1'b1;
      $display("FAIL R%0d step %0d: act=%h rec=%b err=%b inc=%b expected act=%h rec=%b err=%b inc=%b",
               v.rq, idx, act_o, recycle_o, err_o, pend_inc_o, v.act, v.rec, v.err, v.pinc);
    end
    @(posedge clk);
    #1;
    ev_valid = 1'b0;
    if (state_o !== v.nxt) begin
      bad = 1'b1;
      $display("FAIL R%0d step %0d: state=%0d expected %0d", v.rq, idx, state_o, v.nxt);
    end
    if (perm_o !== perm_of(v.nxt)) begin
      bad = 1'b1;
      $display("FAIL R2 step %0d: perm=%0d expected %0d", idx, perm_o, perm_of(v.nxt));
    end
    if (bad) nfail++;
  endtask

  task automatic check_quiet(input logic [3:0] exp_st, input string tag);
    nchk++;
    if (state_o !== exp_st || perm_o !== perm_of(exp_st) || act_o !== XN ||
        recycle_o !== 1'b0 || err_o !== 1'b0 || pend_inc_o !== 1'b0) begin
      nfail++;
      $display("FAIL R1 %s: state=%0d perm=%0d act=%h rec=%b err=%b expected state=%0d perm=%0d act=0 rec=0 err=0",
               tag, state_o, perm_o, act_o, recycle_o, err_o, exp_st, perm_of(exp_st));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check_quiet(QI, "in reset");          // R1
    rst_n = 1'b1;
    @(posedge clk); #1 check_quiet(QI, "after reset");

    for (int i = 0; i < NV; i++) apply(VEC[i], i);

    // R1: no valid, busy other inputs -> nothing happens
    @(negedge clk);
    ev_valid = 1'b0; ev_code = EST; line_dirty = 1'b1;
    repeat (3) @(posedge clk);
    #1 check_quiet(QI, "idle with store code");

    // R12: nack in MI is illegal; R9: dirty exclusive writeback afterwards
    apply('{4'd3,  EST, N,N,N, QIM,  XGETX, N,N,N}, 100);
    apply('{4'd7,  EXD, N,N,N, QMMW, XN,    N,N,N}, 101);
    apply('{4'd8,  ECA, N,N,N, QMM,  XUBM,  N,N,N}, 102);
    apply('{4'd4,  ERP, N,N,N, QMI,  XPUT,  N,N,N}, 103);
    apply('{4'd12, EWN, N,N,N, QMI,  XN,    N,Y,N}, 104);
    apply('{4'd9,  EWA, N,N,Y, QI,   XWXD,  N,N,N}, 105);

    // R6: DMA read leaves M in place; R12: response in a stable state
    apply('{4'd3,  ELD, N,N,N, QIS,  XGETS, N,N,N}, 110);
    apply('{4'd7,  EXD, N,N,N, QMW,  XN,    N,N,N}, 111);
    apply('{4'd8,  ECN, N,N,N, QM,   XUBM,  N,N,N}, 112);
    apply('{4'd6,  EDM, N,N,N, QM,   XDSH,  N,N,N}, 113);
    apply('{4'd12, ESA, N,N,N, QM,   XN,    N,Y,N}, 114);

    // R1: reset in the middle of a transaction returns to I
    apply('{4'd3,  EST, N,N,N, QMM,  XN,    N,N,N}, 120);
    @(negedge clk); rst_n = 1'b0;
    #1 check_quiet(QI, "reset from MM");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check_quiet(QI, "release from MM");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL R1 watchdog: run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule